// File: doc/BRIEF.md
# Power-State Control Register with Wake Request

This block keeps the power-management control and status register of a bus peripheral and drives the peripheral's active-low wake request pin. Software uses one register for three things. It selects a power state from D0 to D3hot. It sets a wake-enable bit. It clears a latched wake-status bit by writing one to it. Wake detectors deliver single-cycle event pulses. A separate mask says which event sources are configured to wake the system. From these inputs the block decides when the wake status is latched and when the wake pin is driven low.

The block also decodes the operating mode for the rest of the peripheral. The modes are normal, low power that can still wake, and sleep. From the same state it derives whether the physical layer stays powered, whether received packets must also pass the wake filter, and whether DMA and ordinary interrupts are allowed. A write that moves the state out of D3hot produces a one-cycle reinitialise pulse for the surrounding configuration space. A synchronous configuration-reset input returns the power state to D0, and wake enable and wake status keep their values through it.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) the register reads 0x0000, pme_n is 1, mode is 0 (normal), phy_on is 1, wake_filter_en is 0, and dma_allow and irq_allow are 1.
- R2: Register layout: bits [1:0] are the power state (0=D0, 1=D1, 2=D2, 3=D3hot), bit 8 is wake enable and bit 15 is wake status. Every other bit ignores writes and reads as 0.
- R3: A wake event is a wake_evt bit that is 1 in a cycle while the same bit of wake_cfg is 1. It sets wake status on the next clock edge, provided wake enable is 1 or the power state is D0. Once set, wake status stays set.
- R4: Wake status clears only when a register write carries 1 in bit 15. A write with 0 in bit 15 leaves it unchanged. When a wake event and a clearing write arrive in the same cycle, the status ends up set.
- R5: pme_n is 0 exactly when wake status and wake enable are both 1. Writing 0 to wake enable releases the pin.
- R6: Wake events are ignored while wake enable is 0 and the power state is not D0. Event bits whose wake_cfg bit is 0 are always ignored.
- R7: A one-cycle pulse on cfg_reset returns the power state to D0. Wake enable and wake status keep their values.
- R8: A register write that changes the power state from D3hot to any other state raises cfg_reinit for exactly one cycle after the write. No other write raises it.
- R9: mode is 0 (normal) in D0 and 1 (wake-capable) in D1 and D2. In D3hot, mode is 1 when wake enable is 1 and wake_cfg is not all zero, and 2 (sleep) otherwise.
- R10: phy_on is 0 only in sleep mode. wake_filter_en equals wake enable.
- R11: dma_allow and irq_allow are 1 only in D0.
- R12: A single write of 0x8103 sets wake enable, selects D3hot and clears wake status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears all state |
| cfg_reset | input | 1 | Synchronous configuration reset, returns the state to D0 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| wake_evt | input | N_EVT | Wake event pulses from the detectors |
| wake_cfg | input | N_EVT | Mask of event sources configured to wake the system |
| pme_n | output | 1 | Wake request pin, active low |
| cfg_reinit | output | 1 | One-cycle pulse after a write that leaves D3hot |
| mode | output | 2 | 0 normal, 1 wake-capable low power, 2 sleep |
| phy_on | output | 1 | Physical layer keeps power |
| wake_filter_en | output | 1 | Packets must also pass the wake filter |
| dma_allow | output | 1 | DMA permitted |
| irq_allow | output | 1 | Ordinary interrupts permitted |

## Verification
The assertions assume that reg_wr, cfg_reset and wake_evt are synchronous to clk and hold steady around each rising edge. They also assume that wake_cfg changes only while no event pulse is in flight, so the qualification an event gets is fixed when it is sampled. The bench meets these assumptions by changing every input on the falling edge and driving at most one pulse per task. Where it wants a wake event and a clearing write in the same cycle, it drives both in the same falling-edge window.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int REG_W    = 16;
  localparam int PS_LO    = 0;
  localparam int PS_W     = 2;
  localparam int EN_BIT   = 8;
  localparam int STS_BIT  = 15;

  typedef enum logic [1:0] {
    PS_D0    = 2'd0,
    PS_D1    = 2'd1,
    PS_D2    = 2'd2,
    PS_D3HOT = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_WAKE   = 2'd1,
    MODE_SLEEP  = 2'd2
  } pm_mode_e;

  // Mode from power state, wake enable and whether any source is configured.
  function automatic pm_mode_e mode_of(input pstate_e ps, input logic en,
                                       input logic any_cfg);
    pm_mode_e m;
    case (ps)
      PS_D0:    m = MODE_NORMAL;
      PS_D1,
      PS_D2:    m = MODE_WAKE;
      default:  m = (en && any_cfg) ? MODE_WAKE : MODE_SLEEP;
    endcase
    return m;
  endfunction

  // Assemble the register image; unlisted bits stay zero.
  function automatic logic [REG_W-1:0] pack_reg(input pstate_e ps,
                                                input logic en,
                                                input logic sts);
    logic [REG_W-1:0] r;
    r = '0;
    r[PS_LO +: PS_W] = ps;
    r[EN_BIT]        = en;
    r[STS_BIT]       = sts;
    return r;
  endfunction
endpackage

// File: rtl/pm_evt_qual.sv
module pm_evt_qual
  import pm_wake_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic [N_EVT-1:0] wake_evt,
  input  logic [N_EVT-1:0] wake_cfg,
  input  logic             en,
  input  pstate_e          ps,
  output logic             evt_hit,
  output logic             any_cfg
);
  logic [N_EVT-1:0] masked;

  for (genvar i = 0; i < N_EVT; i++) begin : g_mask
    assign masked[i] = wake_evt[i] & wake_cfg[i];
  end

  assign any_cfg = |wake_cfg;
  assign evt_hit = (|masked) && (en || ps == PS_D0);
endmodule

// File: rtl/pm_csr_regs.sv
module pm_csr_regs
  import pm_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_reset,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             evt_hit,
  output pstate_e          ps,
  output logic             en,
  output logic             sts,
  output logic             d3_exit
);
  pstate_e ps_wr;
  logic    sts_clr;
  logic    leave_d3;
  logic [REG_W-1:0] unused_wdata;

  assign ps_wr    = pstate_e'(reg_wdata[PS_LO +: PS_W]);
  assign sts_clr  = reg_wr && reg_wdata[STS_BIT];
  assign leave_d3 = reg_wr && (ps == PS_D3HOT) && (ps_wr != PS_D3HOT);
  assign unused_wdata = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps      <= PS_D0;
      en      <= 1'b0;
      sts     <= 1'b0;
      d3_exit <= 1'b0;
    end else begin
      d3_exit <= leave_d3 && !cfg_reset;
      if (cfg_reset)   ps <= PS_D0;
      else if (reg_wr) ps <= ps_wr;
      if (reg_wr)      en <= reg_wdata[EN_BIT];
      if (evt_hit)     sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
  import pm_wake_pkg::*;
(
  input  pstate_e    ps,
  input  logic       en,
  input  logic       sts,
  input  logic       any_cfg,
  output logic [1:0] mode,
  output logic       phy_on,
  output logic       wake_filter_en,
  output logic       dma_allow,
  output logic       irq_allow,
  output logic       pme_n
);
  pm_mode_e m;

  always_comb begin
    m              = mode_of(ps, en, any_cfg);
    mode           = m;
    phy_on         = (m != MODE_SLEEP);
    wake_filter_en = en;
    dma_allow      = (ps == PS_D0);
    irq_allow      = (ps == PS_D0);
    pme_n          = !(en && sts);
  end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_reset,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [N_EVT-1:0] wake_evt,
  input  logic [N_EVT-1:0] wake_cfg,
  output logic             pme_n,
  output logic             cfg_reinit,
  output logic [1:0]       mode,
  output logic             phy_on,
  output logic             wake_filter_en,
  output logic             dma_allow,
  output logic             irq_allow
);
  pstate_e ps_q;
  logic    en_q;
  logic    sts_q;
  logic    evt_hit;
  logic    any_cfg;

  pm_evt_qual #(.N_EVT(N_EVT)) u_qual (
    .wake_evt (wake_evt),
    .wake_cfg (wake_cfg),
    .en       (en_q),
    .ps       (ps_q),
    .evt_hit  (evt_hit),
    .any_cfg  (any_cfg)
  );

  pm_csr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .evt_hit   (evt_hit),
    .ps        (ps_q),
    .en        (en_q),
    .sts       (sts_q),
    .d3_exit   (cfg_reinit)
  );

  pm_mode_decode u_dec (
    .ps             (ps_q),
    .en             (en_q),
    .sts            (sts_q),
    .any_cfg        (any_cfg),
    .mode           (mode),
    .phy_on         (phy_on),
    .wake_filter_en (wake_filter_en),
    .dma_allow      (dma_allow),
    .irq_allow      (irq_allow),
    .pme_n          (pme_n)
  );

  assign reg_rdata = pack_reg(ps_q, en_q, sts_q);
endmodule

// File: rtl/pm_wake_chk.sv
module pm_wake_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [15:0]      reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic             evt_hit,
  input logic             pme_n,
  input logic             cfg_reinit,
  input logic             dma_allow,
  input logic             irq_allow
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h7EFC) == 16'h0000);

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> reg_rdata[15]);

  // R4
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15] && !(reg_wr && reg_wdata[15])) |=> reg_rdata[15]);

  // R5
  pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_n == !(reg_rdata[15] && reg_rdata[8]));

  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[15] && !reg_rdata[8] && reg_rdata[1:0] != 2'd0 && !reg_wr)
      |=> !reg_rdata[15]);

  // R8
  reinit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reinit |=> !cfg_reinit);

  // R11
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'd0) |-> (!dma_allow && !irq_allow));
endmodule

bind pm_wake_ctrl pm_wake_chk #(.N_EVT(N_EVT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .evt_hit    (evt_hit),
  .pme_n      (pme_n),
  .cfg_reinit (cfg_reinit),
  .dma_allow  (dma_allow),
  .irq_allow  (irq_allow)
);

// File: tb/pm_wake_ctrl_bench.sv
module pm_wake_ctrl_bench;
  localparam int NE = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_reset = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NE-1:0] wake_evt = '0;
  logic [NE-1:0] wake_cfg = '0;
  logic pme_n, cfg_reinit, phy_on, wake_filter_en, dma_allow, irq_allow;
  logic [1:0] mode;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pm_wake_ctrl #(.N_EVT(NE)) u_pm_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_evt(wake_evt),
    .wake_cfg(wake_cfg), .pme_n(pme_n), .cfg_reinit(cfg_reinit),
    .mode(mode), .phy_on(phy_on), .wake_filter_en(wake_filter_en),
    .dma_allow(dma_allow), .irq_allow(irq_allow)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic evt(input logic [NE-1:0] m);
    @(negedge clk); wake_evt = m;
    @(negedge clk); wake_evt = '0;
  endtask

  // Expected side outputs from the requirement text.
  task automatic check_side(input string req, input logic [1:0] ps,
                            input logic en, input logic sts);
    logic [1:0] em;
    em = (ps == 2'd0) ? 2'd0 : (ps != 2'd3) ? 2'd1 :
         (en && wake_cfg != '0) ? 2'd1 : 2'd2;
    check({req, " reg"}, reg_rdata, {sts, 6'd0, en, 6'd0, ps});
    check({req, " mode"}, 16'(mode), 16'(em));
    check({req, " phy"}, 16'(phy_on), 16'(em != 2'd2));
    check({req, " filt"}, 16'(wake_filter_en), 16'(en));
    check({req, " dma"}, 16'(dma_allow), 16'(ps == 2'd0));
    check({req, " irq"}, 16'(irq_allow), 16'(ps == 2'd0));
    check({req, " pme"}, 16'(pme_n), 16'(!(en && sts)));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_side("R1", 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_layout;
    wr(16'hFEFE);  // R2: only state=2 lands, reserved bits dropped
    check_side("R2 R9 R11", 2'd2, 1'b0, 1'b0);
    wr(16'h0001);
    check_side("R9 D1", 2'd1, 1'b0, 1'b0);
    wr(16'h0000);
  endtask

  task automatic t_status;
    wake_cfg = 4'b0001;
    evt(4'b0010);  // unconfigured source
    check("R6 unconfigured", reg_rdata, 16'h0000);
    evt(4'b0001);
    check_side("R3 D0 latch", 2'd0, 1'b0, 1'b1);
    wr(16'h0000);
    check("R4 write zero keeps", reg_rdata, 16'h8000);
    wr(16'h0100);
    check("R5 pin low", 16'(pme_n), 16'd0);
    wr(16'h0000);
    check("R5 enable off releases", 16'(pme_n), 16'd1);
    wr(16'h8000);
    check("R4 w1c", reg_rdata, 16'h0000);
  endtask

  task automatic t_setwins;
    wr(16'h0100);
    @(negedge clk); wake_evt = 4'b0001; reg_wr = 1'b1; reg_wdata = 16'h8100;
    @(negedge clk); wake_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    check("R4 set beats clear", reg_rdata, 16'h8100);
    wr(16'h8000);
  endtask

  task automatic t_sleep;
    wr(16'h0003);
    check_side("R9 R10 sleep", 2'd3, 1'b0, 1'b0);
    evt(4'b0001);
    check("R6 sleep ignores", reg_rdata, 16'h0003);
    wr(16'h0000);
  endtask

  task automatic t_magic;
    evt(4'b0001);
    check("R3 pre", reg_rdata, 16'h8000);
    wr(16'h8103);
    check_side("R12 R9 R10", 2'd3, 1'b1, 1'b0);
    @(negedge clk); wake_cfg = '0;
    @(negedge clk);
    check("R9 no sources sleeps", 16'(mode), 16'd2);
    check("R10 phy off", 16'(phy_on), 16'd0);
    @(negedge clk); wake_cfg = 4'b0001;
    evt(4'b0001);
    check_side("R3 R5 wake", 2'd3, 1'b1, 1'b1);
  endtask

  task automatic t_exit;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h0100;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    check("R8 reinit high", 16'(cfg_reinit), 16'd1);
    check("R8 keeps bits", reg_rdata, 16'h8100);
    @(negedge clk);
    check("R8 reinit one cycle", 16'(cfg_reinit), 16'd0);
    wr(16'h0102);
    check("R8 no reinit", 16'(cfg_reinit), 16'd0);
    @(negedge clk); cfg_reset = 1'b1;
    @(negedge clk); cfg_reset = 1'b0;
    check("R7 cfg reset", reg_rdata, 16'h8100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_status();
    t_setwins();
    t_sleep();
    t_magic();
    t_exit();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule